// File: doc/BRIEF.md
# Conversion Result Threshold Monitor

This block watches the stream of conversion results as they are written into the result slots of an analog-to-digital converter. Each compare unit follows one programmed channel and tests every result on that channel against a 12-bit threshold. The unit counts results that meet its condition. When enough of them arrive in a row, it raises a sticky flag and, if enabled, an interrupt. A single condition bit selects "below threshold" or "at or above threshold". An input chooses whether the data and the threshold are read as unsigned or as two's-complement.

The block has `NUM_CMP` independent units (two by default). All units see the same result-write strobe, which carries a valid bit, the channel number and the data. Each unit has its own configuration fields, its own write-one-to-clear strobe for its flag, and its own flag and interrupt outputs. Register decoding and the converter itself sit outside this block.

Top module: `cmp_monitor`

## Requirements
- R1: After reset every flag and interrupt output is low and every match counter is zero.
- R2: When the condition bit is 0 and the format input is 0, a result on the selected channel counts as a match if it is unsigned-less than the threshold. When the condition bit is 1, a result counts if it is unsigned-greater-or-equal to the threshold.
- R3: When the format input is 1, data and threshold are compared as 12-bit two's-complement values.
- R4: The flag is raised in the cycle after the write that brings the run of consecutive matches to the match count plus one (count 0 means one match). The counter then returns to zero. The same applies if the counter is already at or above a count setting that was lowered.
- R5: A result on the selected channel that fails the condition returns the counter to zero.
- R6: Result writes on any other channel neither advance nor reset the counter.
- R7: Channel codes 12 to 15 are reserved. Such a unit never counts and never flags.
- R8: The flag is sticky. A clear strobe lowers it in the next cycle. If a set and a clear fall in the same cycle, the set wins.
- R9: The interrupt output equals the flag ANDed with the unit's interrupt enable.
- R10: While a unit's enable is low, its counter is held at zero and no result counts. An already raised flag is kept.
- R11: Units are independent. Configuration, results and clears of one unit do not affect another unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resWrValid | input | 1 | A conversion result is being written this cycle |
| resWrChan | input | 4 | Channel of the written result |
| resWrData | input | 12 | Written result data |
| signedFmt | input | 1 | 1: two's-complement comparison, 0: unsigned |
| cfgEn | input | NUM_CMP | Per-unit compare enable |
| cfgIe | input | NUM_CMP | Per-unit interrupt enable |
| cfgCond | input | NUM_CMP | Per-unit condition: 0 below, 1 at-or-above |
| cfgChan | input | NUM_CMP*4 | Per-unit selected channel, unit u in bits [u*4 +: 4] |
| cfgMcnt | input | NUM_CMP*4 | Per-unit match count, unit u in bits [u*4 +: 4] |
| cfgThr | input | NUM_CMP*12 | Per-unit threshold, unit u in bits [u*12 +: 12] |
| flagClr | input | NUM_CMP | Per-unit write-one-to-clear strobe for the flag |
| cmpFlag | output | NUM_CMP | Per-unit sticky compare flag |
| cmpIrq | output | NUM_CMP | Per-unit interrupt request |

## Verification
The bench targets the run boundary at count plus one. A design off by one would flag one result early or one result late. It also checks that the counter restarts after a flag; a design that kept counting would flag again too early. Other checks cover a failing result in the middle of a run, and writes on unselected channels in the middle of a run. These catch a counter that ignores a mismatch, or one that a foreign channel clears or advances. Thresholds are chosen so that the signed and unsigned orders disagree, and reserved channel codes are tried. Set and clear arrive in the same cycle, to expose a flag that loses an event. A long random phase runs both units at once, and any crosstalk between them shows up as a flag mismatch.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  // strobes passed from control to the datapath each cycle
  typedef struct packed {
    logic eval;    // a result on the selected channel is being written
    logic clrCnt;  // hold the match counter at zero
  } cmpStrobe_t;
endpackage

// File: rtl/cmp_datapath.sv
module cmp_datapath
  import cmp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int MCNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmpStrobe_t        strb,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] thr,
  input  logic              cond,
  input  logic              signedFmt,
  input  logic [MCNT_W-1:0] mcnt,
  output logic              hitLast
);
  logic [MCNT_W-1:0] cnt;
  logic              below;
  logic              condMet;

  always_comb begin
    if (signedFmt) below = $signed(data) < $signed(thr);
    else           below = data < thr;
    condMet = cond ? !below : below;
    hitLast = strb.eval && condMet && (cnt >= mcnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     cnt <= '0;
    else if (strb.clrCnt)          cnt <= '0;
    else if (strb.eval) begin
      if (!condMet || cnt >= mcnt) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
    end
  end

  // R5
  mismatch_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eval && !condMet) |=> (cnt == '0));
  // R10
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> (cnt == '0));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.eval && !strb.clrCnt) |=> $stable(cnt));
endmodule

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmp_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int NUM_CH = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrValid,
  input  logic [CH_W-1:0] wrChan,
  input  logic            cfgEn,
  input  logic            cfgIe,
  input  logic [CH_W-1:0] cfgChan,
  input  logic            flagClr,
  input  logic            hitLast,
  output cmpStrobe_t      strb,
  output logic            flag,
  output logic            irq
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  always_comb begin
    strb.eval   = wrValid && cfgEn && (wrChan == cfgChan) && (cfgChan <= LAST_CH);
    strb.clrCnt = !cfgEn;
    irq         = flag && cfgIe;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        flag <= 1'b0;
    else if (hitLast) flag <= 1'b1;
    else if (flagClr) flag <= 1'b0;
  end

  // R4
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(hitLast));
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !flagClr) |=> flag);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !hitLast) |=> !flag);
  // R7
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgChan > LAST_CH) |-> !hitLast);
endmodule

// File: rtl/cmp_monitor.sv
module cmp_monitor
  import cmp_pkg::*;
#(
  parameter int NUM_CMP = 2,
  parameter int DATA_W  = 12,
  parameter int CH_W    = 4,
  parameter int NUM_CH  = 12,
  parameter int MCNT_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      resWrValid,
  input  logic [CH_W-1:0]           resWrChan,
  input  logic [DATA_W-1:0]         resWrData,
  input  logic                      signedFmt,
  input  logic [NUM_CMP-1:0]        cfgEn,
  input  logic [NUM_CMP-1:0]        cfgIe,
  input  logic [NUM_CMP-1:0]        cfgCond,
  input  logic [NUM_CMP*CH_W-1:0]   cfgChan,
  input  logic [NUM_CMP*MCNT_W-1:0] cfgMcnt,
  input  logic [NUM_CMP*DATA_W-1:0] cfgThr,
  input  logic [NUM_CMP-1:0]        flagClr,
  output logic [NUM_CMP-1:0]        cmpFlag,
  output logic [NUM_CMP-1:0]        cmpIrq
);
  for (genvar u = 0; u < NUM_CMP; u++) begin : g_unit
    cmpStrobe_t strb;
    logic       hitLast;

    cmp_ctrl #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .wrValid (resWrValid),
      .wrChan  (resWrChan),
      .cfgEn   (cfgEn[u]),
      .cfgIe   (cfgIe[u]),
      .cfgChan (cfgChan[u*CH_W +: CH_W]),
      .flagClr (flagClr[u]),
      .hitLast (hitLast),
      .strb    (strb),
      .flag    (cmpFlag[u]),
      .irq     (cmpIrq[u])
    );

    cmp_datapath #(.DATA_W(DATA_W), .MCNT_W(MCNT_W)) u_dp (
      .clk       (clk),
      .rstN      (rstN),
      .strb      (strb),
      .data      (resWrData),
      .thr       (cfgThr[u*DATA_W +: DATA_W]),
      .cond      (cfgCond[u]),
      .signedFmt (signedFmt),
      .mcnt      (cfgMcnt[u*MCNT_W +: MCNT_W]),
      .hitLast   (hitLast)
    );
  end
endmodule

// File: tb/sim_cmp_monitor.sv
module sim_cmp_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resWrValid = 1'b0;
  logic [3:0]  resWrChan = '0;
  logic [11:0] resWrData = '0;
  logic        signedFmt = 1'b0;
  logic [1:0]  cfgEn = '0, cfgIe = '0, cfgCond = '0, flagClr = '0;
  logic [7:0]  cfgChan = '0, cfgMcnt = '0;
  logic [23:0] cfgThr = '0;
  logic [1:0]  cmpFlag, cmpIrq;

  int    nChecks = 0, nFails = 0;
  string curReq = "R1";
  bit    checking = 1'b0;
  int    mCnt [2];
  bit    mFlag [2];

  always #10 clk = ~clk;  // 50 MHz

  cmp_monitor u0 (.*);

  function automatic int toVal(int d, bit s);
    return (s && d >= 2048) ? d - 4096 : d;
  endfunction

  // behavioural reference model, updated at each rising edge
  always @(posedge clk) begin
    for (int u = 0; u < 2; u++) begin
      int  ch, mc, thr, dv;
      bit  hit, met;
      ch  = int'(cfgChan[u*4 +: 4]);
      mc  = int'(cfgMcnt[u*4 +: 4]);
      thr = toVal(int'(cfgThr[u*12 +: 12]), signedFmt);
      dv  = toVal(int'(resWrData), signedFmt);
      hit = 1'b0;
      if (!rstN) begin
        mCnt[u] = 0; mFlag[u] = 1'b0;
      end else begin
        if (!cfgEn[u]) mCnt[u] = 0;
        else if (resWrValid && int'(resWrChan) == ch && ch < 12) begin
          met = cfgCond[u] ? (dv >= thr) : (dv < thr);
          if (!met) mCnt[u] = 0;
          else if (mCnt[u] >= mc) begin mCnt[u] = 0; hit = 1'b1; end
          else mCnt[u] = mCnt[u] + 1;
        end
        if (hit) mFlag[u] = 1'b1;
        else if (flagClr[u]) mFlag[u] = 1'b0;
      end
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (checking) begin
      for (int u = 0; u < 2; u++) begin
        bit eIrq;
        eIrq = mFlag[u] && cfgIe[u];
        nChecks++;
        if (cmpFlag[u] !== mFlag[u]) begin
          nFails++;
          $display("FAIL %s unit%0d flag actual=%b expected=%b t=%0t", curReq, u, cmpFlag[u], mFlag[u], $time);
        end
        nChecks++;
        if (cmpIrq[u] !== eIrq) begin
          nFails++;
          $display("FAIL %s unit%0d irq actual=%b expected=%b t=%0t", curReq, u, cmpIrq[u], eIrq, $time);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input int ch, input int d);
    resWrValid = 1'b1; resWrChan = 4'(ch); resWrData = 12'(d);
    step();
    resWrValid = 1'b0;
  endtask

  task automatic clr(input int u);
    flagClr[u] = 1'b1; step(); flagClr[u] = 1'b0;
  endtask

  task automatic expectFlag(input int u, input bit v, input string req);
    nChecks++;
    if (cmpFlag[u] !== v) begin
      nFails++;
      $display("FAIL %s unit%0d direct flag actual=%b expected=%b", req, u, cmpFlag[u], v);
    end
  endtask

  task automatic cfgUnit(input int u, input bit en, input bit ie, input bit cond,
                         input int ch, input int mc, input int thr);
    cfgEn[u] = en; cfgIe[u] = ie; cfgCond[u] = cond;
    cfgChan[u*4 +: 4] = 4'(ch); cfgMcnt[u*4 +: 4] = 4'(mc); cfgThr[u*12 +: 12] = 12'(thr);
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog expired in %s", curReq);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    checking = 1'b1;
    step();
    curReq = "R1";
    expectFlag(0, 0, "R1"); expectFlag(1, 0, "R1");

    // R2 below-threshold run of three (count 2)
    curReq = "R2";
    cfgUnit(0, 1, 1, 0, 3, 2, 100);
    cfgUnit(1, 1, 0, 1, 5, 0, 12'h800);
    step();
    wr(3, 50); wr(3, 99);
    expectFlag(0, 0, "R4");
    wr(3, 0);
    expectFlag(0, 1, "R4");
    // R2 at-or-above on unit 1, exact threshold
    wr(5, 12'h800);
    expectFlag(1, 1, "R2");
    wr(5, 12'h7FF);

    // R4 restart after flag: needs three more
    curReq = "R4";
    clr(0);
    expectFlag(0, 0, "R8");
    wr(3, 1); wr(3, 2);
    expectFlag(0, 0, "R4");
    wr(3, 3);
    expectFlag(0, 1, "R4");
    clr(0);

    // R5 mismatch in the middle of a run
    curReq = "R5";
    wr(3, 10); wr(3, 10); wr(3, 100); wr(3, 10); wr(3, 10);
    expectFlag(0, 0, "R5");
    wr(3, 10);
    expectFlag(0, 1, "R5");
    clr(0);

    // R6 foreign channels in the middle of a run
    curReq = "R6";
    wr(3, 10); wr(4, 500); wr(2, 5); wr(3, 10); wr(11, 4000);
    expectFlag(0, 0, "R6");
    wr(3, 10);
    expectFlag(0, 1, "R6");

    // R8 set and clear together: set wins
    curReq = "R8";
    clr(0);
    wr(3, 1); wr(3, 1);
    flagClr[0] = 1'b1; wr(3, 1); flagClr[0] = 1'b0;
    expectFlag(0, 1, "R8");

    // R9 interrupt enable gating
    curReq = "R9";
    cfgIe[0] = 1'b0; step(); step();
    cfgIe[0] = 1'b1; step();
    clr(0);

    // R3 signed: threshold -256, data 5 is above signed, below unsigned
    curReq = "R3";
    signedFmt = 1'b1;
    cfgUnit(0, 1, 1, 1, 7, 0, 12'hF00);
    step();
    wr(7, 5);
    expectFlag(0, 1, "R3");
    clr(0);
    wr(7, 12'hE00);
    expectFlag(0, 0, "R3");
    signedFmt = 1'b0;
    wr(7, 5);
    expectFlag(0, 0, "R3");

    // R7 reserved channel codes
    curReq = "R7";
    for (int c = 12; c < 16; c++) begin
      cfgUnit(0, 1, 1, 1, c, 0, 0);
      step();
      wr(c, 100); wr(c, 4095);
      expectFlag(0, 0, "R7");
    end

    // R10 disable holds counter at zero, keeps flag
    curReq = "R10";
    cfgUnit(0, 1, 1, 0, 1, 1, 200);
    step();
    wr(1, 5);
    cfgEn[0] = 1'b0; step(); cfgEn[0] = 1'b1; step();
    wr(1, 5);
    expectFlag(0, 0, "R10");
    wr(1, 5);
    expectFlag(0, 1, "R10");
    cfgEn[0] = 1'b0; wr(1, 5);
    expectFlag(0, 1, "R10");
    cfgEn[0] = 1'b1; clr(0);

    // R11 random traffic on both units
    curReq = "R11";
    for (int i = 0; i < 3000; i++) begin
      if (i % 300 == 0) begin
        for (int u = 0; u < 2; u++)
          cfgUnit(u, ($urandom % 8) != 0, $urandom % 2, $urandom % 2,
                  $urandom % 14, $urandom % 4, $urandom % 4096);
        signedFmt = $urandom % 2;
      end
      flagClr = ($urandom % 16 == 0) ? 2'($urandom) : 2'b00;
      resWrValid = ($urandom % 3) != 0;
      resWrChan = ($urandom % 2) ? cfgChan[($urandom % 2)*4 +: 4] : 4'($urandom);
      resWrData = 12'($urandom);
      step();
    end
    resWrValid = 1'b0; flagClr = '0;
    step(); step();
    checking = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule